// File: doc/BRIEF.md
# Variable-Latency Sequential Integer Divider

This block performs 32-bit integer division for an RV32M execution unit. A single-cycle start request presents a dividend, a divisor and a two-bit operation code that selects signed or unsigned arithmetic and chooses whether the quotient or the remainder is returned. While it works the block raises `busy`. When the answer is ready it pulses `done` for one cycle, and the answer stays on `result` until the next accepted operation completes.

The latency depends on the operands. A zero divisor, the signed overflow case (most negative value divided by minus one) and a zero dividend are answered at once, one cycle after the start. In all other cases the block counts the leading zeros of the dividend magnitude, aligns the dividend so that its highest set bit enters first, and then runs a restoring shift-subtract loop that yields one quotient bit per cycle. A small dividend therefore finishes in a few cycles rather than the full 32. Signed operations divide the magnitudes and correct the signs at the end. No exception or error indication exists for any operand pair.

Top module: `var_lat_divider`

## Requirements
- R1: Operation code `op` is decoded as: 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder (bit 0 set means unsigned, bit 1 set means remainder). For unsigned codes `result` equals floor(dividend / divisor) or dividend mod divisor.
- R2: For signed codes the quotient is truncated toward zero, so it is negated when the operand signs differ. The remainder carries the sign of the dividend.
- R3: With a zero divisor the quotient is all ones and the remainder equals the dividend, for signed and unsigned codes alike. `done` rises one cycle after the start, `busy` never rises, and the block has no error output.
- R4: A signed code with dividend 0x8000_0000 and divisor 0xFFFF_FFFF returns quotient 0x8000_0000 and remainder 0. `done` rises one cycle after the start.
- R5: A start is accepted at a rising clock edge when `start` is high and `busy` is low. In every other case with a nonzero dividend magnitude of n significant bits, `done` rises n+1 cycles after the start. A zero dividend completes in one cycle with result 0. Latency never exceeds 33 cycles.
- R6: `busy` is high from the cycle after an accepted non-trivial start until the cycle in which `done` rises. `busy` and `done` are never high together.
- R7: `done` is high for one cycle per accepted start. `result` changes only in the cycle in which `done` is high and holds its value otherwise.
- R8: A start while `busy` is high is ignored. The running operation completes with its original operands, code and latency.
- R9: While `rst_n` is low, `busy`, `done` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new operation (accepted only when not busy) |
| op | input | 2 | Operation code, see R1 |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Quotient or remainder of the last completed operation |

## Verification
The bench targets the operand pairs where a sequential divider typically fails. A zero divisor with each code checks that the bypass returns all ones or the dividend instead of running the loop, since a loop would return a wrong remainder sign or an off-by-one latency. The overflow pair catches a design that negates the magnitude quotient and wraps. Dividends of 1, 0, all ones and single high bits exercise the leading-zero alignment, which in a wrong design misses the top quotient bit or takes one step too many. A start injected while busy shows whether the block corrupts its latched operands. Mixed-sign operands check the remainder sign rule separately from the quotient negation.

// File: rtl/div_pkg.sv
// Package: shared types and helpers for the variable-latency divider.
// Assumes the two-bit code layout: bit 0 = unsigned, bit 1 = remainder.
package div_pkg;

    typedef enum logic [1:0] {
        OP_QUO_S = 2'b00,
        OP_QUO_U = 2'b01,
        OP_REM_S = 2'b10,
        OP_REM_U = 2'b11
    } div_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // True when the code asks for signed arithmetic
    function automatic logic op_is_signed(input logic [1:0] code);
        return ~code[0];
    endfunction

    // True when the code asks for the remainder
    function automatic logic op_wants_rem(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/div_lzc.sv
// Leading-zero counter: reports how many zero bits sit above the highest set
// bit of the input. An all-zero input reports W.
// Assumes CW is wide enough to hold W.
module div_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);

    logic seen;

    // Scan from the top bit down and stop at the first one
    always_comb begin
        zeros = CW'(W);
        seen  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen && vec[i]) begin
                zeros = CW'(W - 1 - i);
                seen  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/div_prep.sv
// Operand conditioning: forms magnitudes, detects the cases that bypass the
// loop (zero divisor, signed overflow, zero dividend) and builds their answer,
// and derives the sign corrections to apply after iteration.
// Assumes two's complement operands of width W.
module div_prep
    import div_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [1:0]    code,
    input  logic [W-1:0]  num,
    input  logic [W-1:0]  den,
    output logic [W-1:0]  num_mag,
    output logic [W-1:0]  den_mag,
    output logic [CW-1:0] num_zeros,
    output logic          flip_quo,
    output logic          flip_rem,
    output logic          bypass,
    output logic [W-1:0]  bypass_val
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic sgn;
    logic num_neg;
    logic den_neg;
    logic den_zero;
    logic ovf;
    logic num_zero;

    // Signs and magnitudes of both operands
    always_comb begin
        sgn     = op_is_signed(code);
        num_neg = sgn & num[W-1];
        den_neg = sgn & den[W-1];
        num_mag = num_neg ? (~num + 1'b1) : num;
        den_mag = den_neg ? (~den + 1'b1) : den;
    end

    div_lzc #(.W(W), .CW(CW)) lzc_i (
        .vec   (num_mag),
        .zeros (num_zeros)
    );

    // Classify the cases that skip iteration and form their answer
    always_comb begin
        den_zero = (den == '0);
        ovf      = sgn && (num == MOST_NEG) && (den == '1);
        num_zero = (num == '0);
        bypass   = den_zero | ovf | num_zero;
        if (den_zero) begin
            bypass_val = op_wants_rem(code) ? num : '1;
        end else if (ovf) begin
            bypass_val = op_wants_rem(code) ? '0 : MOST_NEG;
        end else begin
            bypass_val = '0;
        end
    end

    // Sign corrections for the iterated result
    always_comb begin
        flip_quo = num_neg ^ den_neg;
        flip_rem = num_neg;
    end

endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract step: brings the next dividend bit into the
// partial remainder, subtracts the divisor when it fits and shifts the new
// quotient bit into the low end of the quotient register.
// Assumes the partial remainder is always smaller than the divisor.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);

    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    // Trial subtraction and restore decision
    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        trial   = shifted - {1'b0, den};
        fits    = ~trial[W];
        rem_out = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_out = {quo_in[W-2:0], fits};
    end

endmodule

// File: rtl/div_fixup.sv
// Final sign correction and selection between quotient and remainder.
// Assumes quotient and remainder are unsigned magnitudes.
module div_fixup #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         flip_quo,
    input  logic         flip_rem,
    input  logic         want_rem,
    output logic [W-1:0] value
);

    // Negate the chosen magnitude when its sign rule requires it
    always_comb begin
        if (want_rem) begin
            value = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
        end else begin
            value = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
        end
    end

endmodule

// File: rtl/var_lat_divider.sv
// Top: sequential integer divider with data-dependent latency.
// Accepts a start when idle. Trivial cases are answered in one cycle. The
// others run one quotient bit per cycle from the dividend's highest set bit.
// Assumes a synchronous active-low reset and a single clock.
module var_lat_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int CW = $clog2(W + 1);

    div_state_e   state_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] den_q;
    logic [CW-1:0] steps_q;
    logic         flip_quo_q;
    logic         flip_rem_q;
    logic         want_rem_q;
    logic         done_q;
    logic [W-1:0] result_q;

    logic [W-1:0]  num_mag;
    logic [W-1:0]  den_mag;
    logic [CW-1:0] num_zeros;
    logic          flip_quo;
    logic          flip_rem;
    logic          bypass;
    logic [W-1:0]  bypass_val;
    logic [W-1:0]  rem_nxt;
    logic [W-1:0]  quo_nxt;
    logic [W-1:0]  final_val;
    logic          accept;

    div_prep #(.W(W), .CW(CW)) prep_i (
        .code       (op),
        .num        (dividend),
        .den        (divisor),
        .num_mag    (num_mag),
        .den_mag    (den_mag),
        .num_zeros  (num_zeros),
        .flip_quo   (flip_quo),
        .flip_rem   (flip_rem),
        .bypass     (bypass),
        .bypass_val (bypass_val)
    );

    div_step #(.W(W)) step_i (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .den     (den_q),
        .rem_out (rem_nxt),
        .quo_out (quo_nxt)
    );

    div_fixup #(.W(W)) fix_i (
        .quo_mag  (quo_nxt),
        .rem_mag  (rem_nxt),
        .flip_quo (flip_quo_q),
        .flip_rem (flip_rem_q),
        .want_rem (want_rem_q),
        .value    (final_val)
    );

    // A new operation is taken only while idle
    assign accept = start && (state_q == ST_IDLE);

    // Control state, iteration registers and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rem_q      <= '0;
            quo_q      <= '0;
            den_q      <= '0;
            steps_q    <= '0;
            flip_quo_q <= 1'b0;
            flip_rem_q <= 1'b0;
            want_rem_q <= 1'b0;
            done_q     <= 1'b0;
            result_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (bypass) begin
                    result_q <= bypass_val;
                    done_q   <= 1'b1;
                end else begin
                    state_q    <= ST_RUN;
                    rem_q      <= '0;
                    quo_q      <= num_mag << num_zeros;
                    den_q      <= den_mag;
                    steps_q    <= CW'(W) - num_zeros;
                    flip_quo_q <= flip_quo;
                    flip_rem_q <= flip_rem;
                    want_rem_q <= op_wants_rem(op);
                end
            end else if (state_q == ST_RUN) begin
                rem_q   <= rem_nxt;
                quo_q   <= quo_nxt;
                steps_q <= steps_q - 1'b1;
                if (steps_q == CW'(1)) begin
                    state_q  <= ST_IDLE;
                    result_q <= final_val;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    assign busy   = (state_q == ST_RUN);
    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/var_lat_divider_checker.sv
// Checker: temporal properties of the divider ports, bound to every instance
// of the top module. Assumes the same clock and active-low reset.
module var_lat_divider_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [7:0] busy_run;

    // Count consecutive busy cycles to bound the latency window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    assert_zero_div_quo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0 && !op[1]) |=> (done && !busy && result == '1));

    assert_zero_div_rem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0 && op[1]) |=> (done && !busy && result == $past(dividend)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op[0] && dividend == MOST_NEG && divisor == '1)
        |=> (done && result == ($past(op[1]) ? '0 : MOST_NEG)));

    assert_latency_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 8'(W));

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start)));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

endmodule

bind var_lat_divider var_lat_divider_checker #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/var_lat_divider_tb_top.sv
// Bench: directed corner cases plus seeded random operands, compared against
// a behavioural model of results and latency.
module var_lat_divider_tb_top;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic [31:0] dividend;
    logic [31:0] divisor;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int checks;
    int errors;
    bit finished;

    var_lat_divider #(.W(32)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Behavioural result model
    function automatic logic [31:0] model_result(input logic [31:0] a, input logic [31:0] b,
                                                 input logic [1:0] code);
        logic sgn;
        logic rem;
        sgn = ~code[0];
        rem = code[1];
        if (b == 0) return rem ? a : 32'hFFFF_FFFF;
        if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return rem ? 32'h0 : 32'h8000_0000;
        if (sgn) return rem ? 32'($signed(a) % $signed(b)) : 32'($signed(a) / $signed(b));
        return rem ? a % b : a / b;
    endfunction

    // Behavioural latency model (cycles from start edge to done)
    function automatic int model_latency(input logic [31:0] a, input logic [31:0] b,
                                         input logic [1:0] code);
        logic [31:0] mag;
        int bits;
        logic sgn;
        sgn = ~code[0];
        if (b == 0) return 1;
        if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 1;
        mag = (sgn && a[31]) ? -a : a;
        if (mag == 0) return 1;
        bits = 0;
        for (int i = 0; i < 32; i++) if (mag[i]) bits = i + 1;
        return bits + 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Run one operation; optionally inject a foreign start while busy (R8)
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] code,
                          input bit inject, input string req);
        int lat;
        int exp_lat;
        logic [31:0] exp_res;
        logic [31:0] held;
        exp_res = model_result(a, b, code);
        exp_lat = model_latency(a, b, code);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; op = code;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (exp_lat > 1) check(busy == 1'b1, "R6", "busy after start", 32'(busy), 32'd1);
        while (!done && lat < 40) begin
            if (busy && done) check(1'b0, "R6", "busy with done", 32'd1, 32'd0);
            if (inject && lat == 1) begin
                start = 1'b1; dividend = 32'h7FFF_0001; divisor = 32'd3; op = 2'b11;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(result == exp_res, req, "result", result, exp_res);
        check(lat == exp_lat, "R5", "latency", 32'(lat), 32'(exp_lat));
        check(!busy, "R6", "busy low at done", 32'(busy), 32'd0);
        held = result;
        @(negedge clk);
        check(done == 1'b0, "R7", "done pulse width", 32'(done), 32'd0);
        @(negedge clk);
        check(result == held, "R7", "result hold", result, held);
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        void'($urandom(32'd1234));
        checks = 0; errors = 0; finished = 0;
        rst_n = 1'b0; start = 1'b0; op = 2'b00; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy == 1'b0, "R9", "busy in reset", 32'(busy), 32'd0);
        check(done == 1'b0, "R9", "done in reset", 32'(done), 32'd0);
        check(result == '0, "R9", "result in reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: zero divisor, every code
        for (int c = 0; c < 4; c++) run_op(32'hDEAD_BEEF, 32'd0, 2'(c), 1'b0, "R3");
        run_op(32'd0, 32'd0, 2'b10, 1'b0, "R3");
        // R4: signed overflow
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 2'b00, 1'b0, "R4");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 2'b10, 1'b0, "R4");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 2'b01, 1'b0, "R1");
        // R5: zero dividend, smallest and largest magnitudes
        run_op(32'd0, 32'd7, 2'b00, 1'b0, "R5");
        run_op(32'd1, 32'd1, 2'b01, 1'b0, "R5");
        run_op(32'hFFFF_FFFF, 32'd1, 2'b01, 1'b0, "R5");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11, 1'b0, "R5");
        run_op(32'h8000_0000, 32'd3, 2'b01, 1'b0, "R5");
        run_op(32'hFFFF_FFFF, 32'd2, 2'b00, 1'b0, "R5");
        // R2: sign combinations
        run_op(32'hFFFF_FFF9, 32'd2, 2'b00, 1'b0, "R2");
        run_op(32'hFFFF_FFF9, 32'd2, 2'b10, 1'b0, "R2");
        run_op(32'd7, 32'hFFFF_FFFE, 2'b00, 1'b0, "R2");
        run_op(32'd7, 32'hFFFF_FFFE, 2'b10, 1'b0, "R2");
        run_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 2'b10, 1'b0, "R2");
        run_op(32'h8000_0000, 32'd7, 2'b10, 1'b0, "R2");
        // R1: unsigned with large operands
        run_op(32'hF000_0000, 32'h0000_0011, 2'b01, 1'b0, "R1");
        run_op(32'hF000_0000, 32'h0000_0011, 2'b11, 1'b0, "R1");
        run_op(32'd5, 32'd9, 2'b11, 1'b0, "R1");
        // R8: start while busy is ignored
        run_op(32'h1234_5678, 32'd17, 2'b00, 1'b1, "R8");
        run_op(32'h0000_0003, 32'd2, 2'b10, 1'b1, "R8");

        // Random operands with varied magnitudes
        for (int k = 0; k < 300; k++) begin
            ra = $urandom() >> ($urandom() % 32);
            rb = $urandom() >> ($urandom() % 32);
            if ($urandom() % 4 == 0) ra = -ra;
            if ($urandom() % 4 == 0) rb = -rb;
            if ($urandom() % 40 == 0) rb = 32'd0;
            run_op(ra, rb, 2'($urandom() % 4), ($urandom() % 8) == 0, "R1");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule